// File: doc/BRIEF.md
# MAC multiply and accumulator saturation

This block is the arithmetic core of a multiply-accumulate engine. It holds four 48-bit accumulators. It forms a 32x32 product in one of three number formats: unsigned, signed integer or signed fraction. It can add that product into a selected accumulator, detecting overflow at both stages. When the saturate-on-overflow control is set, an overflowing result is clamped to a format-specific limit. A sticky overflow flag, plus one sticky overflow flag per accumulator, records what happened until a status write replaces them.

Each cycle with `op_valid` high performs one operation, selected by `op_code`:
- 0: multiply only
- 1: multiply and accumulate
- 2: load an accumulator
- 3: write the status flags

Every operation finishes at the next rising clock edge. The product output is combinational from the operands and the mode inputs. The accumulator outputs always show the accumulator chosen by `acc_sel`.

The number format comes from two mode inputs, with fraction taking priority over signed. The fraction product can be rounded to a 24-bit boundary with ties going to even.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset every accumulator reads 0, `v_flag` is 0 and `pav_flags` is 0.
- R2: The format is chosen as follows: `frac_mode`=1 selects fraction regardless of `signed_mode`; otherwise `signed_mode`=1 selects signed; otherwise unsigned. A signed product is the 64-bit two's complement product. It overflows when it differs from its own low 40 bits sign-extended. With `sat_on_ovf`=1 an overflowing signed product becomes +2^50 (non-negative product) or -2^50 (negative product); with `sat_on_ovf`=0 it passes unchanged.
- R3: An unsigned product overflows when any of bits 63:40 are set. On overflow it becomes 2^50 with `sat_on_ovf`=1, and otherwise it is cut to its low 40 bits.
- R4: A fraction product is the signed 64-bit product and never reports overflow. With `round_en`=1 the product is rounded and its low 24 bits are cleared. The low 24 bits are the remainder, and the part above them is the quotient. The quotient is incremented when the remainder exceeds 0x800000. At exactly 0x800000 it is incremented only if it is odd. With `round_en`=0 the product is unchanged.
- R5: A multiply-accumulate extends the selected accumulator to 64 bits, zero-extended in unsigned format and sign-extended from bit 47 otherwise. It adds the product, and writes the saturated low 48 bits of the sum back to that accumulator.
- R6: In signed format the sum overflows when it does not fit 48-bit signed. With `sat_on_ovf`=1 the result is 0x00007FFFFFFF for a non-negative sum and 0xFFFF80000000 for a negative sum; otherwise it is the low 48 bits of the sum.
- R7: In unsigned format the sum overflows when bits 63:48 are nonzero. With `sat_on_ovf`=1 the result is 0xFFFFFFFFFFFF, or 0 when the sum exceeds 2^53; otherwise it is the low 48 bits of the sum.
- R8: In fraction format the sum overflows when it does not fit 48-bit signed. With `sat_on_ovf`=1 the result is 0x7FFFFFFFFFFF for a non-negative sum and 0x800000000000 for a negative sum.
- R9: `v_flag` is set by a multiply with product overflow, or by a multiply-accumulate with product or sum overflow. Once set it stays set until a status write.
- R10: After a multiply-accumulate in which `v_flag` ends up set, bit `acc_sel` of `pav_flags` is set. It is sticky until a status write.
- R11: A status write loads `v_flag` from `op_a[0]` and `pav_flags[i]` from `op_a[i+1]`; accumulators are unchanged.
- R12: A load writes `{op_b[15:0], op_a}` to the selected accumulator and leaves the flags unchanged.
- R13: `acc_rd32` is the selected accumulator read as a signed value. It is the low 32 bits when the value fits 32-bit signed, and otherwise 0x7FFFFFFF for a positive value or 0x80000000 for a negative one.
- R14: With `op_valid` low, no accumulator or flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies the operation this cycle |
| op_code | input | 2 | 0 multiply, 1 multiply-accumulate, 2 load, 3 status write |
| frac_mode | input | 1 | Fraction format (priority over signed) |
| signed_mode | input | 1 | Signed integer format |
| sat_on_ovf | input | 1 | Saturate or force on overflow |
| round_en | input | 1 | Round fraction products |
| acc_sel | input | IDX_W (2) | Accumulator index |
| op_a | input | 32 | First operand; load low word; status data |
| op_b | input | 32 | Second operand; load high half in bits 15:0 |
| prod_out | output | 64 | Product after format handling |
| acc_out | output | 48 | Selected accumulator |
| acc_rd32 | output | 32 | Selected accumulator, saturated to 32-bit signed |
| v_flag | output | 1 | Sticky overflow flag |
| pav_flags | output | NUM_ACC (4) | Sticky per-accumulator overflow flags |

## Verification
The assertions assume that `acc_sel` stays below `NUM_ACC` and that `op_code` and the mode inputs are driven to known values throughout. They also assume that `op_valid` goes high only once reset has been released. The stimulus changes every input only at the falling edge and draws `acc_sel` from its two-bit range. It scales random operands by random right shifts, so that both fitting and overflowing products and sums occur in all three formats.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;
  localparam int OPW       = 32;
  localparam int PRW       = 2 * OPW;
  localparam int ACW       = 48;
  localparam int GDW       = 40;
  localparam int RND_W     = 24;
  localparam int FORCE_BIT = 50;
  localparam int WRAP_BIT  = 53;

  typedef enum logic [1:0] {OP_MUL, OP_MAC, OP_LOAD, OP_STAT} mac_op_e;
  typedef enum logic [1:0] {MD_UNS, MD_SGN, MD_FRAC, MD_RSVD} mac_mode_e;

  typedef struct packed {
    logic [PRW-1:0] val;
    logic           ovf;
  } prod_t;

  typedef struct packed {
    logic [ACW-1:0] val;
    logic           ovf;
  } sat_t;

  function automatic mac_mode_e pick_mode(input logic frac, input logic sgn);
    if (frac)     return MD_FRAC;
    else if (sgn) return MD_SGN;
    else          return MD_UNS;
  endfunction

  function automatic prod_t mul_stage(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                                      input mac_mode_e mode, input logic omc, input logic rnd);
    prod_t          r;
    logic [PRW-1:0] sa, sb, q, force_v;
    logic [RND_W-1:0] rem;
    logic [RND_W-1:0] half;
    sa      = {{(PRW-OPW){a[OPW-1]}}, a};
    sb      = {{(PRW-OPW){b[OPW-1]}}, b};
    force_v = PRW'(1) << FORCE_BIT;
    half    = {1'b1, {(RND_W-1){1'b0}}};
    r.ovf   = 1'b0;
    case (mode)
      MD_UNS: begin
        r.val = {{(PRW-OPW){1'b0}}, a} * {{(PRW-OPW){1'b0}}, b};
        r.ovf = |r.val[PRW-1:GDW];
        if (r.ovf) r.val = omc ? force_v : {{(PRW-GDW){1'b0}}, r.val[GDW-1:0]};
      end
      MD_SGN: begin
        r.val = sa * sb;
        r.ovf = r.val != {{(PRW-GDW){r.val[GDW-1]}}, r.val[GDW-1:0]};
        if (r.ovf && omc) r.val = r.val[PRW-1] ? (~force_v + PRW'(1)) : force_v;
      end
      default: begin
        r.val = sa * sb;
        if (rnd) begin
          q   = {{RND_W{r.val[PRW-1]}}, r.val[PRW-1:RND_W]};
          rem = r.val[RND_W-1:0];
          if (rem > half)       q = q + PRW'(1);
          else if (rem == half) q = q + PRW'(q[0]);
          r.val = q << RND_W;
        end
      end
    endcase
    return r;
  endfunction

  function automatic logic [PRW-1:0] acc_extend(input logic [ACW-1:0] acc, input mac_mode_e mode);
    if (mode == MD_UNS) return {{(PRW-ACW){1'b0}}, acc};
    return {{(PRW-ACW){acc[ACW-1]}}, acc};
  endfunction

  function automatic sat_t sat_stage(input logic [PRW-1:0] sum, input mac_mode_e mode,
                                     input logic omc);
    sat_t r;
    r.val = sum[ACW-1:0];
    if (mode == MD_UNS) begin
      r.ovf = |sum[PRW-1:ACW];
      if (r.ovf && omc)
        r.val = (sum > (PRW'(1) << WRAP_BIT)) ? '0 : {ACW{1'b1}};
    end else begin
      r.ovf = sum != {{(PRW-ACW){sum[ACW-1]}}, sum[ACW-1:0]};
      if (r.ovf && omc) begin
        if (mode == MD_SGN)
          r.val = sum[PRW-1] ? {{(ACW-OPW+1){1'b1}}, {(OPW-1){1'b0}}}
                             : {{(ACW-OPW+1){1'b0}}, {(OPW-1){1'b1}}};
        else
          r.val = sum[PRW-1] ? {1'b1, {(ACW-1){1'b0}}} : {1'b0, {(ACW-1){1'b1}}};
      end
    end
    return r;
  endfunction

  function automatic logic [OPW-1:0] read_sat32(input logic [ACW-1:0] acc);
    if ((&acc[ACW-1:OPW-1]) || !(|acc[ACW-1:OPW-1])) return acc[OPW-1:0];
    return acc[ACW-1] ? {1'b1, {(OPW-1){1'b0}}} : {1'b0, {(OPW-1){1'b1}}};
  endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult
  import mac_sat_pkg::*;
(
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  input  mac_mode_e      mode,
  input  logic           omc,
  input  logic           rnd,
  output logic [PRW-1:0] prod,
  output logic           prod_ovf
);
  prod_t res;
  always_comb begin
    res      = mul_stage(a, b, mode, omc, rnd);
    prod     = res.val;
    prod_ovf = res.ovf;
  end
endmodule

// File: rtl/mac_accsat.sv
module mac_accsat
  import mac_sat_pkg::*;
(
  input  logic [ACW-1:0] acc_in,
  input  logic [PRW-1:0] prod,
  input  mac_mode_e      mode,
  input  logic           omc,
  output logic [ACW-1:0] acc_new,
  output logic           sum_ovf
);
  logic [PRW-1:0] sum;
  sat_t           res;
  always_comb begin
    sum     = acc_extend(acc_in, mode) + prod;
    res     = sat_stage(sum, mode, omc);
    acc_new = res.val;
    sum_ovf = res.ovf;
  end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank
  import mac_sat_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = $clog2(NUM_ACC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] sel,
  input  logic [ACW-1:0]   wdata,
  output logic [ACW-1:0]   rdata
);
  logic [ACW-1:0]         acc_r [NUM_ACC];
  logic [NUM_ACC*ACW-1:0] acc_flat;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           acc_r[g] <= '0;
      else if (we && sel == IDX_W'(g))      acc_r[g] <= wdata;
    end
    assign acc_flat[g*ACW +: ACW] = acc_r[g];
  end

  assign rdata = acc_r[sel];

  // R14
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(acc_flat));
  // R5
  write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> acc_r[$past(sel)] == $past(wdata));
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_sat_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = $clog2(NUM_ACC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [1:0]         op_code,
  input  logic               frac_mode,
  input  logic               signed_mode,
  input  logic               sat_on_ovf,
  input  logic               round_en,
  input  logic [IDX_W-1:0]   acc_sel,
  input  logic [OPW-1:0]     op_a,
  input  logic [OPW-1:0]     op_b,
  output logic [PRW-1:0]     prod_out,
  output logic [ACW-1:0]     acc_out,
  output logic [OPW-1:0]     acc_rd32,
  output logic               v_flag,
  output logic [NUM_ACC-1:0] pav_flags
);
  mac_op_e   op;
  mac_mode_e mode;
  logic      do_mul, do_mac, do_load, do_stat;
  logic      prod_ovf, sum_ovf, ovf_event, bank_we;
  logic [ACW-1:0] sat_res, bank_wdata;
  logic           v_q;
  logic [NUM_ACC-1:0] pav_q;

  assign op      = mac_op_e'(op_code);
  assign mode    = pick_mode(frac_mode, signed_mode);
  assign do_mul  = op_valid && op == OP_MUL;
  assign do_mac  = op_valid && op == OP_MAC;
  assign do_load = op_valid && op == OP_LOAD;
  assign do_stat = op_valid && op == OP_STAT;

  mac_mult u_mult (
    .a(op_a), .b(op_b), .mode(mode), .omc(sat_on_ovf), .rnd(round_en),
    .prod(prod_out), .prod_ovf(prod_ovf)
  );

  mac_accsat u_sat (
    .acc_in(acc_out), .prod(prod_out), .mode(mode), .omc(sat_on_ovf),
    .acc_new(sat_res), .sum_ovf(sum_ovf)
  );

  assign ovf_event  = (do_mul && prod_ovf) || (do_mac && (prod_ovf || sum_ovf));
  assign bank_we    = do_mac || do_load;
  assign bank_wdata = do_mac ? sat_res : {op_b[ACW-OPW-1:0], op_a};

  mac_acc_bank #(.NUM_ACC(NUM_ACC), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .sel(acc_sel),
    .wdata(bank_wdata), .rdata(acc_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      pav_q <= '0;
    end else if (do_stat) begin
      v_q   <= op_a[0];
      pav_q <= op_a[NUM_ACC:1];
    end else begin
      if (ovf_event) v_q <= 1'b1;
      if (do_mac && (v_q || ovf_event)) pav_q[acc_sel] <= 1'b1;
    end
  end

  assign v_flag    = v_q;
  assign pav_flags = pav_q;
  assign acc_rd32  = read_sat32(acc_out);

  // R9
  v_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_q && !do_stat |=> v_q);
  // R10
  pav_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_mac && ovf_event |=> pav_q[$past(acc_sel)]);
  // R13
  rd32_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd32[OPW-1] == acc_out[ACW-1]);
  // R8
  frac_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_mac && mode == MD_FRAC && sat_on_ovf && sum_ovf |=>
      (acc_out == {1'b0, {(ACW-1){1'b1}}} || acc_out == {1'b1, {(ACW-1){1'b0}}}
       || $past(acc_sel) != acc_sel));
  // R2
  sgn_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MD_SGN && sat_on_ovf && prod_ovf |->
      (prod_out == (PRW'(1) << FORCE_BIT) || prod_out == (~(PRW'(1) << FORCE_BIT) + PRW'(1))));
endmodule

// File: tb/sim_mac_sat_unit.sv
module sim_mac_sat_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 100000;

  logic        clk = 0, rst_n = 0;
  logic        op_valid = 0, frac_mode = 0, signed_mode = 0, sat_on_ovf = 0, round_en = 0;
  logic [1:0]  op_code = 0, acc_sel = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic [63:0] prod_out;
  logic [47:0] acc_out;
  logic [31:0] acc_rd32;
  logic        v_flag;
  logic [3:0]  pav_flags;

  int n_chk = 0, n_fail = 0;
  logic [47:0] macc [4];
  logic        mv;
  logic [3:0]  mpav;
  logic [63:0] seen_prod;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_sat_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .frac_mode(frac_mode), .signed_mode(signed_mode), .sat_on_ovf(sat_on_ovf),
    .round_en(round_en), .acc_sel(acc_sel), .op_a(op_a), .op_b(op_b),
    .prod_out(prod_out), .acc_out(acc_out), .acc_rd32(acc_rd32),
    .v_flag(v_flag), .pav_flags(pav_flags)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] m_prod(input logic [31:0] a, b, input logic fr, sg, om, rn,
                                         output logic ovf);
    longint s, q, r;
    longint unsigned u;
    ovf = 0;
    if (fr) begin
      s = longint'($signed(a)) * longint'($signed(b));
      if (rn) begin
        q = s >>> 24;
        r = s & 64'hFF_FFFF;
        if (r > 64'h80_0000) q = q + 1;
        else if (r == 64'h80_0000 && q[0]) q = q + 1;
        s = q <<< 24;
      end
      return s;
    end else if (sg) begin
      s = longint'($signed(a)) * longint'($signed(b));
      ovf = ((s <<< 24) >>> 24) != s;
      if (ovf && om) s = (s < 0) ? -(64'sd1 <<< 50) : (64'sd1 <<< 50);
      return s;
    end else begin
      u = {32'h0, a} * {32'h0, b};
      ovf = (u >> 40) != 0;
      if (ovf) u = om ? (64'd1 << 50) : (u & 64'hFF_FFFF_FFFF);
      return u;
    end
  endfunction

  function automatic logic [47:0] m_sat(input logic [63:0] sum, input logic fr, sg, om,
                                        output logic ovf);
    longint ss;
    ss = sum;
    if (!fr && !sg) begin
      ovf = (sum >> 48) != 0;
      if (ovf && om) return (sum > (64'd1 << 53)) ? 48'h0 : 48'hFFFF_FFFF_FFFF;
      return sum[47:0];
    end
    ovf = ((ss <<< 16) >>> 16) != ss;
    if (ovf && om) begin
      if (fr) return (ss < 0) ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
      return (ss < 0) ? 48'hFFFF_8000_0000 : 48'h0000_7FFF_FFFF;
    end
    return sum[47:0];
  endfunction

  function automatic logic [31:0] m_rd32(input logic [47:0] v);
    longint s;
    s = longint'($signed(v));
    if (s > 64'sd2147483647)  return 32'h7FFF_FFFF;
    if (s < -64'sd2147483648) return 32'h8000_0000;
    return v[31:0];
  endfunction

  task automatic do_op(input logic [1:0] op, input logic fr, sg, om, rn,
                       input logic [1:0] sel, input logic [31:0] a, b);
    logic [63:0] ep, ext, sum;
    logic        pov, sov;
    string       ptag, atag, vtag;
    ep   = m_prod(a, b, fr, sg, om, rn, pov);
    ptag = fr ? (sg ? "R2" : "R4") : (sg ? "R2" : "R3");
    atag = "R14";
    vtag = "R9";
    @(negedge clk);
    op_valid = 1; op_code = op; frac_mode = fr; signed_mode = sg;
    sat_on_ovf = om; round_en = rn; acc_sel = sel; op_a = a; op_b = b;
    #1;
    if (op == 2'd0 || op == 2'd1) chk(ptag, prod_out, ep);
    seen_prod = prod_out;
    case (op)
      2'd0: if (pov) mv = 1;
      2'd1: begin
        ext  = (!fr && !sg) ? {16'h0, macc[sel]} : {{16{macc[sel][47]}}, macc[sel]};
        sum  = ext + ep;
        macc[sel] = m_sat(sum, fr, sg, om, sov);
        if (pov || sov) mv = 1;
        if (mv) mpav[sel] = 1;
        atag = fr ? "R8" : (sg ? "R6" : "R7");
        vtag = "R10";
      end
      2'd2: begin macc[sel] = {b[15:0], a}; atag = "R12"; end
      default: begin mv = a[0]; mpav = a[4:1]; vtag = "R11"; end
    endcase
    @(posedge clk); #1;
    chk(atag, acc_out, macc[sel]);
    chk(vtag, v_flag, mv);
    chk(vtag, pav_flags, mpav);
    chk("R13", acc_rd32, m_rd32(macc[sel]));
  endtask

  task automatic idle(input logic [31:0] junk);
    @(negedge clk);
    op_valid = 0; op_code = junk[1:0]; acc_sel = junk[3:2];
    frac_mode = junk[4]; signed_mode = junk[5]; sat_on_ovf = junk[6];
    op_a = junk; op_b = ~junk;
    @(posedge clk); #1;
    chk("R14", acc_out, macc[junk[3:2]]);
    chk("R14", v_flag, mv);
    chk("R14", pav_flags, mpav);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R14 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb, rj;
    logic [1:0]  rop;
    void'($urandom(32'd77123));
    for (int i = 0; i < 4; i++) macc[i] = '0;
    mv = 0; mpav = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", v_flag, 1'b0);
    chk("R1", pav_flags, 4'h0);
    for (int i = 0; i < 4; i++) begin
      acc_sel = 2'(i); #1;
      chk("R1", acc_out, 48'h0);
    end
    @(negedge clk) rst_n = 1;

    // R2: signed overflow forced to +2^50
    do_op(2'd0, 0, 1, 1, 0, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    chk("R2", seen_prod, 64'h0004_0000_0000_0000);
    chk("R9", v_flag, 1'b1);
    // R11: status write
    do_op(2'd3, 0, 0, 0, 0, 2'd0, 32'h0000_0016, 32'h0);
    chk("R11", pav_flags, 4'hB);
    do_op(2'd3, 0, 0, 0, 0, 2'd0, 32'h0, 32'h0);
    // R3: unsigned truncation
    do_op(2'd0, 0, 0, 0, 0, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R3", seen_prod, 64'h0000_00FE_0000_0001);
    do_op(2'd3, 0, 0, 0, 0, 2'd0, 32'h0, 32'h0);
    // R4: rounding ties to even, above half
    do_op(2'd0, 1, 0, 0, 1, 2'd0, 32'h0180_0000, 32'h1);
    chk("R4", seen_prod, 64'h0200_0000);
    do_op(2'd0, 1, 0, 0, 1, 2'd0, 32'h0080_0000, 32'h1);
    chk("R4", seen_prod, 64'h0);
    do_op(2'd0, 1, 0, 0, 1, 2'd0, 32'h0080_0001, 32'h1);
    chk("R4", seen_prod, 64'h0100_0000);
    // R2: fraction wins over signed
    do_op(2'd0, 1, 1, 1, 1, 2'd0, 32'h0180_0000, 32'h1);
    chk("R2", seen_prod, 64'h0200_0000);
    // R8: fraction clamp
    do_op(2'd2, 0, 0, 0, 0, 2'd1, 32'hFFFF_0000, 32'h0000_7FFF);
    do_op(2'd1, 1, 0, 1, 0, 2'd1, 32'h4000_0000, 32'h4000_0000);
    chk("R8", acc_out, 48'h7FFF_FFFF_FFFF);
    chk("R10", pav_flags[1], 1'b1);
    do_op(2'd3, 0, 0, 0, 0, 2'd0, 32'h0, 32'h0);
    // R6: signed negative clamp, R13 read
    do_op(2'd2, 0, 0, 0, 0, 2'd2, 32'h0, 32'h0000_8000);
    do_op(2'd1, 0, 1, 1, 0, 2'd2, 32'hFFFF_FFFF, 32'h1);
    chk("R6", acc_out, 48'hFFFF_8000_0000);
    chk("R13", acc_rd32, 32'h8000_0000);
    // R7: unsigned clamp and truncation
    do_op(2'd2, 0, 0, 0, 0, 2'd3, 32'hFFFF_FFFF, 32'h0000_FFFF);
    do_op(2'd1, 0, 0, 1, 0, 2'd3, 32'h1, 32'h1);
    chk("R7", acc_out, 48'hFFFF_FFFF_FFFF);
    do_op(2'd1, 0, 0, 0, 0, 2'd3, 32'h1, 32'h1);
    chk("R7", acc_out, 48'h0);
    idle(32'h0000_00FF);

    for (int i = 0; i < 3000; i++) begin
      rop = 2'($urandom % 4);
      if (rop == 2'd3 && ($urandom % 4) != 0) rop = 2'd1;
      ra = $urandom >> ($urandom % 33);
      rb = $urandom >> ($urandom % 33);
      rj = $urandom;
      if (($urandom % 10) == 0) idle(rj);
      else do_op(rop, rj[0], rj[1], rj[2], rj[3], rj[5:4], ra, rb);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule